// File: doc/BRIEF.md
# Thermal Event Output Controller

This block watches a stream of signed temperature samples and decides whether an active-low, open-drain event line should be pulled low. Each accepted sample is stored in a current-temperature register that software can read at any time. The stored value is compared against two programmable limits, an upper one and a lower one, that bound a normal window. It is also compared against a critical limit that carries its own hysteresis.

Software picks one of three behaviours for the line. In comparator mode the line follows the out-of-window condition directly. In interrupt mode an excursion out of the window is latched until software acknowledges it with a write-one-to-clear bit. In critical-only mode the window is ignored and only the critical comparison matters. The critical comparison always acts as a comparator with hysteresis, whichever mode is selected. A global enable bit releases the line whenever it is clear. Temperatures and limits are two's-complement values in quarter-degree steps.

The register port is a plain synchronous interface. Writes take effect at the clock edge. Reads are combinational from the address. The line itself is presented as a single "pull low" control for an external pad.

Top module: `thermal_event_ctrl`

## Requirements
- R1: After reset the line is released (`evt_pull_low`=0). The config register (address 0) reads 0, the temperature register (address 6) reads 0, the upper limit (address 1) and critical limit (address 3) read the largest positive value, and the lower limit (address 2) reads the most negative value.
- R2: A sample is captured into the temperature register only in a cycle with `samp_valid`=1. Address 6 reads it sign-extended to the data width, and the captured value holds while `samp_valid`=0.
- R3: When config bit 0 (enable) is 0, the line is released in every mode.
- R4: In comparator mode (config bits 2:1 = 1, and also for code 3), the line is pulled low while the temperature is strictly above the upper limit or strictly below the lower limit. It is released when the temperature is back inside the window, and a value equal to a limit counts as inside. The line reflects a sample two clock edges after the sample is accepted.
- R5: In interrupt mode (config bits 2:1 = 0), a transition from inside to outside the window sets an event latch that pulls the line low. The latch stays set after the temperature returns inside, until a write with bit 0 = 1 to the status register (address 5) clears it.
- R6: Writing bit 0 = 0 to the status register leaves the event latch unchanged. Status bit 0 always reads 0, and status bit 1 reads the event latch.
- R7: A critical state sets when the temperature is strictly above the critical limit (address 3). It stays set until the temperature is strictly below the critical limit minus the hysteresis (address 4, unsigned). The line is pulled low while this state is set, in every mode, provided the block is enabled.
- R8: In critical-only mode (config bits 2:1 = 2), excursions out of the upper/lower window do not pull the line low, and the line follows the critical state alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | Sample strobe |
| samp_temp | input | TW | Signed temperature sample, quarter-degree steps |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on address) |
| evt_pull_low | output | 1 | 1 drives the event pad low, 0 releases it |

## Verification
The comparator mode is driven through a walk of temperatures around both limits, including values equal to each limit. This separates strict from non-strict comparison and shows the line release without software action. Interrupt mode is tried with a rise out of the window and a return inside, which separates latching from following. A zero write to the clear bit is then shown to be inert, while a one write releases the line. Critical-only mode and critical behaviour in comparator mode are tried with a descent through the hysteresis band, which separates a plain threshold from one with hysteresis. The enable bit and a held sample strobe confirm gating and capture.

// File: rtl/thermal_event_ctrl.sv
module thermal_event_ctrl #(
  parameter int TW = 13,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_valid,
  input  logic [TW-1:0] samp_temp,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          evt_pull_low
);

  localparam logic [AW-1:0] A_CFG  = AW'(0);
  localparam logic [AW-1:0] A_HI   = AW'(1);
  localparam logic [AW-1:0] A_LO   = AW'(2);
  localparam logic [AW-1:0] A_CRIT = AW'(3);
  localparam logic [AW-1:0] A_HYST = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);
  localparam logic [AW-1:0] A_TEMP = AW'(6);
  localparam logic [1:0] M_INT  = 2'd0;
  localparam logic [1:0] M_CRIT = 2'd2;
  localparam logic signed [TW-1:0] T_MAX = {1'b0, {(TW-1){1'b1}}};
  localparam logic signed [TW-1:0] T_MIN = {1'b1, {(TW-1){1'b0}}};
  localparam int XW = DW - TW;

  logic                 en_q;
  logic [1:0]           mode_q;
  logic signed [TW-1:0] hi_q, lo_q, crit_lim_q, temp_q;
  logic [TW-2:0]        hyst_q;
  logic                 win_q, lat_q, crit_q, pull_q;

  logic                 clr_evt, above, below, win_nx, lat_nx, crit_nx, pull_nx;
  logic signed [TW:0]   crit_floor, temp_x;

  assign clr_evt = reg_wr && reg_addr == A_STAT && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      mode_q     <= M_INT;
      hi_q       <= T_MAX;
      lo_q       <= T_MIN;
      crit_lim_q <= T_MAX;
      hyst_q     <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CFG:  begin en_q <= reg_wdata[0]; mode_q <= reg_wdata[2:1]; end
        A_HI:   hi_q       <= reg_wdata[TW-1:0];
        A_LO:   lo_q       <= reg_wdata[TW-1:0];
        A_CRIT: crit_lim_q <= reg_wdata[TW-1:0];
        A_HYST: hyst_q     <= reg_wdata[TW-2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          temp_q <= '0;
    else if (samp_valid) temp_q <= samp_temp;
  end

  assign above      = temp_q > hi_q;
  assign below      = temp_q < lo_q;
  assign win_nx     = above | below;
  assign temp_x     = {temp_q[TW-1], temp_q};
  assign crit_floor = {crit_lim_q[TW-1], crit_lim_q} - $signed({2'b00, hyst_q});
  assign crit_nx    = (temp_q > crit_lim_q) | (crit_q & !(temp_x < crit_floor));

  always_comb begin
    if (!en_q || mode_q != M_INT) lat_nx = 1'b0;
    else if (win_nx && !win_q)    lat_nx = 1'b1;
    else if (clr_evt)             lat_nx = 1'b0;
    else                          lat_nx = lat_q;
  end

  always_comb begin
    case (mode_q)
      M_INT:   pull_nx = lat_nx | crit_nx;
      M_CRIT:  pull_nx = crit_nx;
      default: pull_nx = win_nx | crit_nx;
    endcase
    pull_nx = pull_nx & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      lat_q  <= 1'b0;
      crit_q <= 1'b0;
      pull_q <= 1'b0;
    end else begin
      win_q  <= win_nx;
      lat_q  <= lat_nx;
      crit_q <= crit_nx;
      pull_q <= pull_nx;
    end
  end

  assign evt_pull_low = pull_q;

  always_comb begin
    case (reg_addr)
      A_CFG:   reg_rdata = {{(DW-3){1'b0}}, mode_q, en_q};
      A_HI:    reg_rdata = {{XW{hi_q[TW-1]}}, hi_q};
      A_LO:    reg_rdata = {{XW{lo_q[TW-1]}}, lo_q};
      A_CRIT:  reg_rdata = {{XW{crit_lim_q[TW-1]}}, crit_lim_q};
      A_HYST:  reg_rdata = {{(DW-TW+1){1'b0}}, hyst_q};
      A_STAT:  reg_rdata = {{(DW-5){1'b0}}, crit_q, below, above, lat_q, 1'b0};
      A_TEMP:  reg_rdata = {{XW{temp_q[TW-1]}}, temp_q};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/thermal_event_ctrl_chk.sv
module thermal_event_ctrl_chk #(
  parameter int TW = 13,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [1:0]           mode,
  input logic                 lat,
  input logic                 crit,
  input logic                 pull,
  input logic signed [TW-1:0] temp,
  input logic signed [TW-1:0] upper,
  input logic                 reg_wr,
  input logic [AW-1:0]        reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [DW-1:0]        reg_rdata
);

  logic clr;
  assign clr = reg_wr && reg_addr == AW'(5) && reg_wdata[0];

  p_off_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pull);

  p_cmp_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'd1 && temp > upper) |=> pull);

  p_int_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'd0 && lat && !clr) |=> pull);

  p_clr_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(5)) |-> !reg_rdata[0]);

  p_crit_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 2'd2) |=> (pull == crit));

endmodule

bind thermal_event_ctrl thermal_event_ctrl_chk #(.TW(TW), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .mode(mode_q), .lat(lat_q), .crit(crit_q),
  .pull(pull_q), .temp(temp_q), .upper(hi_q), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/tb_thermal_event_ctrl.sv
module tb_thermal_event_ctrl;
  localparam int TW = 13;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam time CLK_PERIOD = 10ns;

  localparam int NV = 8;
  localparam int VT [NV] = '{0, 100, 101, 50, -40, -41, -200, 20};
  localparam int VP [NV] = '{0, 0,   1,   0,  0,   1,   1,    0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_valid = 1'b0;
  logic [TW-1:0] samp_temp = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic evt_pull_low;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_event_ctrl #(.TW(TW), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .samp_valid(samp_valid), .samp_temp(samp_temp),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_pull_low(evt_pull_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    v = int'($signed(reg_rdata));
  endtask

  task automatic samp(input int t);
    @(negedge clk);
    samp_valid = 1'b1; samp_temp = TW'(t);
    @(negedge clk);
    samp_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pin(input string tag, input int exp);
    chk(tag, int'(evt_pull_low), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    pin("R1 pin", 0);
    rd(0, v); chk("R1 cfg", v, 0);
    rd(6, v); chk("R1 temp", v, 0);
    rd(1, v); chk("R1 upper", v, 4095);
    rd(2, v); chk("R1 lower", v, -4096);
    rd(3, v); chk("R1 crit", v, 4095);

    // R4 comparator walk
    wr(1, 100); wr(2, -40);
    wr(0, 3);
    for (int i = 0; i < NV; i++) begin
      samp(VT[i]);
      chk($sformatf("R4 vec%0d temp %0d", i, VT[i]), int'(evt_pull_low), VP[i]);
    end

    // R2 capture and hold
    samp(-41);
    rd(6, v); chk("R2 readback", v, -41);
    @(negedge clk); samp_temp = TW'(77);
    repeat (3) @(negedge clk);
    rd(6, v); chk("R2 hold", v, -41);
    pin("R4 held low", 1);

    // R3 disable releases
    wr(0, 2);
    repeat (2) @(negedge clk);
    pin("R3 disabled", 0);
    samp(20);

    // R5/R6 interrupt mode
    wr(0, 1);
    samp(150); pin("R5 set", 1);
    samp(0);   pin("R5 latched", 1);
    rd(5, v);  chk("R6 status bit1", (v >> 1) & 1, 1);
    chk("R6 status bit0", v & 1, 0);
    wr(5, 0); repeat (2) @(negedge clk);
    pin("R6 write0", 1);
    wr(5, 1); repeat (2) @(negedge clk);
    pin("R5 cleared", 0);
    samp(-100); pin("R5 reentry low", 1);
    wr(5, 1); repeat (2) @(negedge clk);
    pin("R5 clear2", 0);

    // R8/R7 critical-only
    samp(0);
    wr(3, 200); wr(4, 20);
    wr(0, 5);
    samp(150);  pin("R8 window ignored", 0);
    samp(-100); pin("R8 low ignored", 0);
    samp(200);  pin("R7 equal not crit", 0);
    samp(201);  pin("R7 crit set", 1);
    samp(185);  pin("R7 hyst hold", 1);
    samp(180);  pin("R7 floor hold", 1);
    samp(179);  pin("R7 release", 0);
    samp(190);  pin("R7 no reset in band", 0);

    // R7 critical in comparator mode with hysteresis
    wr(1, 300);
    wr(0, 3);
    samp(250); pin("R7 cmp crit", 1);
    samp(190); pin("R7 cmp band", 1);
    samp(170); pin("R7 cmp release", 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule